// File: doc/BRIEF.md
# I2C Register Target with Retained Pointer

This block is an I2C target that lets a bus host read and write a bank of 8-bit registers. It watches the SCL and SDA lines, recognises START, repeated START and STOP, compares the 7-bit device address against its own, and keeps a register pointer between transfers. The register bank lives outside the block and is reached through a synchronous write port and a registered-read port. The read port returns data one clock after the address is presented, which suits an inferred block RAM.

In a write transfer, the first byte after the address loads the pointer. Every later byte is written to the register under the pointer, and the pointer then advances. A read transfer with no pointer byte before it continues from wherever the last write left the pointer. A random read loads the pointer in a short write, issues a repeated START and then reads. Both the read and write paths advance the pointer after each byte and wrap from the top register to 0. Bus lines are brought into the system clock domain through a flop synchronizer followed by an edge detector. SDA is driven through an output enable: when the enable is 1, the line is pulled low.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset, `sda_oe` is 0, `reg_we` is 0 and `reg_rd_addr` (the pointer) is 0.
- R2: The address byte is `{address[6:0], dir}` sent MSB first, with dir 0 for write and 1 for read. The target pulls SDA low in the ninth (ACK) bit only when the address equals `DEV_ADDR`. For any other address it leaves SDA released until the next START or STOP and performs no writes.
- R3: In a write transfer, the first byte after the address loads the pointer from its low `REG_AW` bits. Each later byte produces one single-cycle `reg_we` pulse with `reg_waddr` equal to the pointer, and the pointer then advances by one. Every byte received by an addressed target is acknowledged.
- R4: A read transfer that has no pointer byte before it starts at the register the pointer was left at by the last write.
- R5: A write carrying only the pointer byte, followed by a repeated START and a read address, reads from that pointer.
- R6: Read data is driven MSB first and the pointer advances after every byte sent. When the host answers a byte with NACK (SDA high), the target drives nothing more until the next START.
- R7: Advancing the pointer past register 2^REG_AW-1 wraps it to 0, for both reads and writes.
- R8: A STOP or START that arrives before the eighth bit of a data byte abandons that byte, and no register is written.
- R9: `sda_oe` changes only while the synchronized SCL is low, and it is 0 in the cycle after a STOP is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line as seen at the pin |
| sda_i | input | 1 | I2C data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_rd_addr | output | REG_AW | Register read address (current pointer) |
| reg_rd_data | input | 8 | Register data, valid one clock after `reg_rd_addr` |
| reg_we | output | 1 | Single-cycle register write strobe |
| reg_waddr | output | REG_AW | Register write address |
| reg_wdata | output | 8 | Register write data |

## Verification
The completion of a data byte does two things in the same clock: it issues the write strobe for the current pointer and it advances that pointer. The bench provokes this with multi-byte bursts, including one that runs across the top register so the advance and the wrap land on the same edge as a write. It then judges the result by reading the registers back over the bus and by checking that each strobe is followed by a pointer one above its write address. A STOP landing in the middle of a byte is also exercised, to show that the abort wins and no strobe is issued.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_WAIT,
    ST_ACK,
    ST_RX,
    ST_TX,
    ST_TX_REL,
    ST_HACK,
    ST_WAIT
  } tgt_state_e;

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES:0] scl_q;
  logic [STAGES:0] sda_q;
  logic            scl_p;
  logic            sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[STAGES-1:0], scl_i};
      sda_q <= {sda_q[STAGES-1:0], sda_i};
    end
  end

  assign scl_s = scl_q[STAGES-1];
  assign sda_s = sda_q[STAGES-1];
  assign scl_p = scl_q[STAGES];
  assign sda_p = sda_q[STAGES];

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  // data edges while the clock is steadily high mark bus conditions
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_tgt_ptr.sv
module i2c_tgt_ptr #(
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [REG_AW-1:0] load_val,
  input  logic              inc,
  output logic [REG_AW-1:0] ptr
);

  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= ptr + 1'b1;  // natural wrap at the top register
  end

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2C,
  parameter int         REG_AW   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [REG_AW-1:0] ptr,
  input  logic [7:0]        rd_data,
  output logic              ptr_load,
  output logic [REG_AW-1:0] ptr_load_val,
  output logic              ptr_inc,
  output logic              sda_oe,
  output logic              reg_we,
  output logic [REG_AW-1:0] reg_waddr,
  output logic [7:0]        reg_wdata
);

  tgt_state_e  state;
  logic [2:0]  bit_cnt;
  logic [6:0]  rx_sh;
  logic [6:0]  tx_sh;
  logic        dir_rd;
  logic        first_byte;
  logic        host_ack;
  logic [7:0]  rx_byte;
  logic        last_bit;
  logic        rx_done;
  logic        tx_done;

  assign rx_byte  = {rx_sh, sda_s};
  assign last_bit = (bit_cnt == 3'd7);
  assign rx_done  = scl_rise && last_bit && (state == ST_RX) && !start_det && !stop_det;
  assign tx_done  = scl_rise && last_bit && (state == ST_TX) && !start_det && !stop_det;

  assign ptr_load     = rx_done && first_byte;
  assign ptr_load_val = rx_byte[REG_AW-1:0];
  assign ptr_inc      = (rx_done && !first_byte) || tx_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      dir_rd     <= 1'b0;
      first_byte <= 1'b0;
      host_ack   <= 1'b0;
      sda_oe     <= 1'b0;
      reg_we     <= 1'b0;
      reg_waddr  <= '0;
      reg_wdata  <= '0;
    end else begin
      reg_we <= 1'b0;
      if (start_det) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: if (scl_rise) begin
            rx_sh   <= rx_byte[6:0];
            bit_cnt <= bit_cnt + 3'd1;
            if (last_bit) begin
              if (rx_byte[7:1] == DEV_ADDR) begin
                dir_rd     <= rx_byte[0];
                first_byte <= ~rx_byte[0];
                state      <= ST_ACK_WAIT;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          ST_ACK_WAIT: if (scl_fall) begin
            sda_oe <= 1'b1;
            state  <= ST_ACK;
          end
          ST_ACK: if (scl_fall) begin
            bit_cnt <= '0;
            if (dir_rd) begin
              tx_sh  <= rd_data[6:0];
              sda_oe <= ~rd_data[7];
              state  <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_RX;
            end
          end
          ST_RX: if (scl_rise) begin
            rx_sh   <= rx_byte[6:0];
            bit_cnt <= bit_cnt + 3'd1;
            if (last_bit) begin
              if (!first_byte) begin
                reg_we    <= 1'b1;
                reg_waddr <= ptr;
                reg_wdata <= rx_byte;
              end
              first_byte <= 1'b0;
              state      <= ST_ACK_WAIT;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              sda_oe <= ~tx_sh[6];
              tx_sh  <= {tx_sh[5:0], 1'b0};
            end
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 3'd1;
              if (last_bit) state <= ST_TX_REL;
            end
          end
          ST_TX_REL: if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_HACK;
          end
          ST_HACK: begin
            if (scl_rise) host_ack <= ~sda_s;
            if (scl_fall) begin
              if (host_ack) begin
                tx_sh   <= rd_data[6:0];
                sda_oe  <= ~rd_data[7];
                bit_cnt <= '0;
                state   <= ST_TX;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h2C,
  parameter int         REG_AW      = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [REG_AW-1:0] reg_rd_addr,
  input  logic [7:0]        reg_rd_data,
  output logic              reg_we,
  output logic [REG_AW-1:0] reg_waddr,
  output logic [7:0]        reg_wdata
);

  logic              scl_s;
  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              ptr_load;
  logic              ptr_inc;
  logic [REG_AW-1:0] ptr_load_val;
  logic [REG_AW-1:0] ptr;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_tgt_ptr #(.REG_AW(REG_AW)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .load     (ptr_load),
    .load_val (ptr_load_val),
    .inc      (ptr_inc),
    .ptr      (ptr)
  );

  i2c_tgt_fsm #(.DEV_ADDR(DEV_ADDR), .REG_AW(REG_AW)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .sda_s        (sda_s),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .ptr          (ptr),
    .rd_data      (reg_rd_data),
    .ptr_load     (ptr_load),
    .ptr_load_val (ptr_load_val),
    .ptr_inc      (ptr_inc),
    .sda_oe       (sda_oe),
    .reg_we       (reg_we),
    .reg_waddr    (reg_waddr),
    .reg_wdata    (reg_wdata)
  );

  assign reg_rd_addr = ptr;

endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk #(
  parameter int REG_AW = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_s,
  input logic              start_det,
  input logic              stop_det,
  input logic              sda_oe,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_waddr,
  input logic [REG_AW-1:0] ptr
);

  assert_we_single_R3: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  // write strobe and pointer advance share one edge; includes the wrap
  assert_ptr_after_write_R7: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> (ptr == REG_AW'(reg_waddr + 1'b1)));

  assert_start_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (!sda_oe && !reg_we));

  assert_stop_release_R9: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

endmodule

bind i2c_reg_target i2c_reg_target_chk #(.REG_AW(REG_AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_oe    (sda_oe),
  .reg_we    (reg_we),
  .reg_waddr (reg_waddr),
  .ptr       (ptr)
);

// File: tb/tb_i2c_reg_target.sv
module tb_i2c_reg_target;

  localparam int         CLK_PERIOD = 10;
  localparam int         QTR        = 10;
  localparam int         AW         = 4;
  localparam int         NREG       = 1 << AW;
  localparam logic [6:0] DEV        = 7'h2C;
  localparam int         NVEC       = 8;
  // {register[3:0], data[7:0]}
  localparam logic [11:0] VEC [NVEC] = '{12'h0A5, 12'h13C, 12'h2FF, 12'h700,
                                         12'h881, 12'hF5A, 12'hAC3, 12'h47E};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic h_scl = 1'b1;
  logic h_sda_low = 1'b0;
  logic sda_line;
  logic sda_oe;
  logic [AW-1:0] reg_rd_addr;
  logic [7:0] reg_rd_data;
  logic reg_we;
  logic [AW-1:0] reg_waddr;
  logic [7:0] reg_wdata;

  logic [7:0] mem [NREG];
  logic [7:0] exp_mem [NREG];
  logic [7:0] wbuf [NREG];
  logic [7:0] rbuf [NREG];
  logic [AW-1:0] exp_ptr;
  int checks = 0;
  int fails = 0;
  int we_count = 0;
  int oe_bad = 0;
  logic oe_prev = 1'b0;
  logic last_ack;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = ~(h_sda_low | sda_oe);

  i2c_reg_target #(.DEV_ADDR(DEV), .REG_AW(AW), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .scl_i(h_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata));

  // register bank model with registered read
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= 8'(i * 17);
    end else if (reg_we) begin
      mem[reg_waddr] <= reg_wdata;
    end
    reg_rd_data <= mem[reg_rd_addr];
  end

  always @(posedge clk) if (!rst && reg_we) we_count++;

  // R9: output enable must not move while the host holds SCL high
  always @(negedge clk) begin
    if (!rst && (sda_oe !== oe_prev) && h_scl) oe_bad++;
    oe_prev = sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq;
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start;
    h_sda_low = 1'b0; wq;
    h_scl = 1'b1; wq;
    h_sda_low = 1'b1; wq;
    h_scl = 1'b0; wq;
  endtask

  task automatic bus_stop;
    h_sda_low = 1'b1; wq;
    h_scl = 1'b1; wq;
    h_sda_low = 1'b0; wq;
  endtask

  task automatic send_bit(input logic b);
    h_sda_low = ~b; wq;
    h_scl = 1'b1; wq; wq;
    h_scl = 1'b0; wq;
  endtask

  task automatic recv_bit(output logic b);
    h_sda_low = 1'b0; wq;
    h_scl = 1'b1; wq;
    b = sda_line; wq;
    h_scl = 1'b0; wq;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    acked = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~ack);
  endtask

  task automatic wr_tx(input logic [AW-1:0] p, input int n);
    logic a;
    bus_start;
    send_byte({DEV, 1'b0}, a); last_ack = a;
    send_byte(8'(p), a);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a);
      exp_mem[AW'(p + AW'(i))] = wbuf[i];
    end
    bus_stop;
    exp_ptr = AW'(p + AW'(n));
  endtask

  task automatic rd_plain(input int n);
    logic a;
    bus_start;
    send_byte({DEV, 1'b1}, a);
    for (int i = 0; i < n; i++) recv_byte(rbuf[i], i != n - 1);
    bus_stop;
  endtask

  task automatic rd_rand(input logic [AW-1:0] p, input int n);
    logic a;
    bus_start;
    send_byte({DEV, 1'b0}, a);
    send_byte(8'(p), a);
    bus_start;
    send_byte({DEV, 1'b1}, a);
    for (int i = 0; i < n; i++) recv_byte(rbuf[i], i != n - 1);
    bus_stop;
    exp_ptr = AW'(p + AW'(n));
  endtask

  initial begin
    int wec;
    logic a;
    logic [7:0] d;
    for (int i = 0; i < NREG; i++) exp_mem[i] = 8'(i * 17);
    exp_ptr = '0;
    repeat (5) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sda_oe", 32'(sda_oe), 32'd0);
    chk("R1 reg_we", 32'(reg_we), 32'd0);
    chk("R1 pointer", 32'(reg_rd_addr), 32'd0);
    wq;

    // table walk: single write then random read of the same register (R3, R5)
    for (int v = 0; v < NVEC; v++) begin
      wbuf[0] = VEC[v][7:0];
      wr_tx(VEC[v][11:8], 1);
      chk("R2 own address acked", 32'(last_ack), 32'd1);
      rd_rand(VEC[v][11:8], 1);
      chk("R3/R5 write then random read", 32'(rbuf[0]), 32'(exp_mem[VEC[v][11:8]]));
    end

    // burst write with increment, then plain read continues after it (R3, R4)
    wec = we_count;
    for (int i = 0; i < 4; i++) wbuf[i] = 8'h30 + 8'(i);
    wr_tx(4'd3, 4);
    chk("R3 one strobe per data byte", 32'(we_count - wec), 32'd4);
    rd_plain(1);
    chk("R4 plain read after burst", 32'(rbuf[0]), 32'(exp_mem[exp_ptr]));
    exp_ptr = exp_ptr + 1'b1;
    for (int i = 0; i < 4; i++) begin
      chk("R3 burst byte", 32'(mem[3 + i]), 32'(8'h30 + 8'(i)));
    end

    // pointer-only write, then plain multi-byte read (R4, R6)
    wr_tx(4'd9, 0);
    rd_plain(4);
    for (int i = 0; i < 4; i++) begin
      chk("R4/R6 plain read sequence", 32'(rbuf[i]), 32'(exp_mem[9 + i]));
    end

    // wrap on write and read (R7)
    wbuf[0] = 8'hE1; wbuf[1] = 8'hE2; wbuf[2] = 8'hE3;
    wr_tx(4'd14, 3);
    chk("R7 write wrapped to reg 0", 32'(mem[0]), 32'hE3);
    rd_rand(4'd15, 2);
    chk("R7 read at top", 32'(rbuf[0]), 32'hE2);
    chk("R7 read wrapped", 32'(rbuf[1]), 32'hE3);

    // foreign address is ignored (R2)
    wec = we_count;
    bus_start;
    send_byte({7'h2D, 1'b0}, a);
    chk("R2 foreign address not acked", 32'(a), 32'd0);
    send_byte(8'h02, a);
    chk("R2 no ack after foreign address", 32'(a), 32'd0);
    send_byte(8'hEE, a);
    bus_stop;
    chk("R2 no write for foreign address", 32'(we_count - wec), 32'd0);
    rd_rand(4'd2, 1);
    chk("R2 register untouched", 32'(rbuf[0]), 32'(exp_mem[2]));

    // host NACK ends the read; target stays silent (R6)
    bus_start;
    send_byte({DEV, 1'b1}, a);
    recv_byte(d, 1'b0);
    chk("R6 read byte before NACK", 32'(d), 32'(exp_mem[exp_ptr]));
    recv_byte(d, 1'b0);
    chk("R6 silent after NACK", 32'(d), 32'hFF);
    chk("R6 sda released", 32'(sda_oe), 32'd0);
    bus_stop;

    // STOP in the middle of a data byte (R8)
    wec = we_count;
    bus_start;
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h05, a);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_stop;
    chk("R8 no write on STOP abort", 32'(we_count - wec), 32'd0);
    rd_rand(4'd5, 1);
    chk("R8 register kept after STOP abort", 32'(rbuf[0]), 32'(exp_mem[5]));

    // repeated START in the middle of a data byte (R8, R5)
    wec = we_count;
    bus_start;
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h06, a);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_start;
    send_byte({DEV, 1'b1}, a);
    recv_byte(d, 1'b0);
    bus_stop;
    chk("R8 no write on START abort", 32'(we_count - wec), 32'd0);
    chk("R8/R5 read after START abort", 32'(d), 32'(exp_mem[6]));

    chk("R9 sda_oe moved while SCL high", 32'(oe_bad), 32'd0);
    chk("R9 sda released at idle", 32'(sda_oe), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule